// File: doc/BRIEF.md
# Packed SIMD Saturating Adder-Subtractor

This unit adds or subtracts two 64-bit packed vectors lane by lane for a multimedia coprocessor datapath. At run time a format select splits each vector into eight byte lanes or four halfword lanes. An operation select chooses addition or subtraction. All lanes are treated as unsigned, and each lane is computed on its own, with no carry or borrow crossing a lane edge.

A saturate enable chooses how a lane result that does not fit is handled. With it clear, the lane wraps modulo its width. With it set, the result is clamped to the lane's unsigned range. Next to the 64-bit result the unit reports which lanes were clamped.

Operands and controls are captured on a valid strobe. The result, the clamp flags and a valid flag appear one clock later. The outputs hold their last values until the next strobe.

Top module: `simd_sat_addsub`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `result` and `sat_flags` to zero.
- R2: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low otherwise. `result` and `sat_flags` reflect the operands and controls sampled at that edge.
- R3: At an edge where `in_valid` is low, `result` and `sat_flags` keep their previous values, whatever the other inputs are.
- R4: With `fmt_half`=0 the vectors are eight byte lanes. Lane i occupies bits [8i+7:8i]. Without saturation each lane result is (a+b) mod 256 or (a−b) mod 256, and adjacent lanes are unaffected.
- R5: With `fmt_half`=1 the vectors are four halfword lanes. Lane i occupies bits [16i+15:16i]. Without saturation each lane result is (a+b) mod 65536 or (a−b) mod 65536.
- R6: `op_sub`=0 selects addition. With `sat_en`=1, a lane sum above the lane maximum (255 or 65535) becomes that maximum. For bytes, 150+170 gives 255 and 50+80 gives 130.
- R7: `op_sub`=1 selects subtraction (a−b). With `sat_en`=1, a lane difference below zero becomes 0. For bytes, 120−135 gives 0.
- R8: Bit i of `sat_flags` is 1 exactly when lane i was clamped. All bits are 0 when `sat_en`=0. Bits [7:4] are 0 in halfword format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for operands and controls |
| src_a | input | 64 | First operand vector |
| src_b | input | 64 | Second operand vector (subtrahend) |
| fmt_half | input | 1 | 0: eight 8-bit lanes, 1: four 16-bit lanes |
| op_sub | input | 1 | 0: add, 1: subtract |
| sat_en | input | 1 | 1: clamp lane results, 0: wrap |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Lane-wise result vector |
| sat_flags | output | 8 | Per-lane clamp indicator |

## Verification
The hardest case is a vector where clamped and unclamped lanes sit side by side, because a carry or borrow leaking over a lane edge then shows up only in the neighbouring lane. Directed vectors alternate saturating and in-range lanes in both formats. Random operands are also drawn lane by lane from extreme and middle values, so mixed patterns occur often. Hold cycles with changed inputs and a low strobe are placed between operations to expose any capture without a strobe.

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              fmt_half,
  input  logic              op_sub,
  input  logic              sat_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W/8-1:0] sat_flags
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;

  logic [DATA_W-1:0] b_res, h_res;
  logic [NB-1:0]     b_clamp;
  logic [NH-1:0]     h_clamp;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [8:0] ext;
    assign ext = op_sub ? {1'b0, src_a[8*i +: 8]} - {1'b0, src_b[8*i +: 8]}
                        : {1'b0, src_a[8*i +: 8]} + {1'b0, src_b[8*i +: 8]};
    assign b_clamp[i] = sat_en & ext[8];
    assign b_res[8*i +: 8] = b_clamp[i] ? (op_sub ? 8'h00 : 8'hFF) : ext[7:0];
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    logic [16:0] ext;
    assign ext = op_sub ? {1'b0, src_a[16*i +: 16]} - {1'b0, src_b[16*i +: 16]}
                        : {1'b0, src_a[16*i +: 16]} + {1'b0, src_b[16*i +: 16]};
    assign h_clamp[i] = sat_en & ext[16];
    assign h_res[16*i +: 16] = h_clamp[i] ? (op_sub ? 16'h0000 : 16'hFFFF) : ext[15:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= fmt_half ? h_res : b_res;
        sat_flags <= fmt_half ? {{(NB-NH){1'b0}}, h_clamp} : b_clamp;
      end
    end
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(in_valid) |-> $stable(result) && $stable(sat_flags));

  p_no_flags_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid) && !$past(sat_en) |-> sat_flags == '0);

  p_half_upper_flags_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_valid) && $past(fmt_half) |-> sat_flags[NB-1:NH] == '0);

  for (genvar i = 0; i < NB; i++) begin : g_chk
    p_byte_clamp_value_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(in_valid) && !$past(fmt_half) && sat_flags[i]
      |-> result[8*i +: 8] == ($past(op_sub) ? 8'h00 : 8'hFF));
  end
endmodule

// File: tb/test_simd_sat_addsub.sv
module test_simd_sat_addsub;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1, in_valid = 0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        fmt_half = 0, op_sub = 0, sat_en = 0;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  sat_flags;

  int compared = 0, mismatched = 0;
  logic [63:0] exp_r = '0;
  logic [7:0]  exp_f = '0;

  always #(CLK_P/2) clk = ~clk;

  simd_sat_addsub i_simd_sat_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .fmt_half(fmt_half), .op_sub(op_sub), .sat_en(sat_en),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags));

  function automatic void model(input logic [63:0] a, b, input logic h, s, t,
                                output logic [63:0] r, output logic [7:0] f);
    int w = h ? 16 : 8;
    int n = 64 / w;
    longint unsigned mx = (64'd1 << w) - 1;
    r = '0; f = '0;
    for (int i = 0; i < n; i++) begin
      longint signed x = longint'((a >> (w*i)) & mx);
      longint signed y = longint'((b >> (w*i)) & mx);
      longint signed v = s ? x - y : x + y;
      if (t && v > longint'(mx)) begin v = longint'(mx); f[i] = 1; end
      else if (t && v < 0) begin v = 0; f[i] = 1; end
      r |= (64'(v) & mx) << (w*i);
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] r, input logic [7:0] f, input logic v);
    compared++;
    if (result !== r || sat_flags !== f || out_valid !== v) begin
      mismatched++;
      $display("FAIL %s: result=%h flags=%b valid=%b expected result=%h flags=%b valid=%b",
               tag, result, sat_flags, out_valid, r, f, v);
    end
  endtask

  task automatic op(input string tag, input logic [63:0] a, b, input logic h, s, t);
    @(negedge clk);
    src_a = a; src_b = b; fmt_half = h; op_sub = s; sat_en = t; in_valid = 1;
    model(a, b, h, s, t, exp_r, exp_f);
    @(negedge clk);
    in_valid = 0;
    check(tag, exp_r, exp_f, 1'b1);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
    fmt_half = 1'($urandom); op_sub = 1'($urandom); sat_en = 1'($urandom);
    in_valid = 0;
    @(negedge clk);
    check(tag, exp_r, exp_f, 1'b0);
  endtask

  function automatic logic [63:0] lanes_rand();
    logic [63:0] v;
    for (int i = 0; i < 8; i++)
      case ($urandom % 4)
        0: v[8*i +: 8] = 8'h00;
        1: v[8*i +: 8] = 8'hFF;
        default: v[8*i +: 8] = 8'($urandom);
      endcase
    return v;
  endfunction

  initial begin
    #(CLK_P * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250917));
    src_a = '1; src_b = '1; in_valid = 1;
    repeat (3) @(negedge clk);
    check("R1 reset state", 64'h0, 8'h0, 1'b0);
    rst = 0; in_valid = 0;
    @(negedge clk);
    check("R1 after reset idle", 64'h0, 8'h0, 1'b0);

    op("R6 byte sat 150+170 / 50+80", 64'h0000_0000_0000_3296, 64'h0000_0000_0000_50AA, 0, 0, 1);
    if (result[7:0] !== 8'd255 || result[15:8] !== 8'd130) begin
      mismatched++; $display("FAIL R6 lanes got %0d %0d expected 255 130", result[7:0], result[15:8]);
    end
    compared++;
    op("R7 byte sat 120-135", 64'h0000_0000_0000_0078, 64'h0000_0000_0000_0087, 0, 1, 1);
    if (result[7:0] !== 8'd0 || sat_flags !== 8'h01) begin
      mismatched++; $display("FAIL R7 lane got %0d flags %b expected 0 00000001", result[7:0], sat_flags);
    end
    compared++;
    idle("R3 hold after sat sub");
    op("R4 byte wrap add no cross-lane", 64'hFF01_FF01_FF01_FF01, 64'h01FF_01FF_01FF_01FF, 0, 0, 0);
    op("R4 byte wrap sub borrow", 64'h0080_0080_0080_0080, 64'h0100_0100_0100_0100, 0, 1, 0);
    op("R5 half wrap add", 64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_1111, 1, 0, 0);
    op("R5 half wrap sub", 64'h0000_0001_0100_FFFF, 64'h0001_0002_0001_0000, 1, 1, 0);
    op("R6 half sat add", 64'hFFFF_8000_0010_7FFF, 64'h0001_8000_0020_8000, 1, 0, 1);
    op("R7 half sat sub", 64'h0000_00FF_1000_FFFF, 64'h0001_0100_0FFF_FFFF, 1, 1, 1);
    if (sat_flags[7:4] !== 4'h0) begin
      mismatched++; $display("FAIL R8 upper flags %b expected 0000", sat_flags[7:4]);
    end
    compared++;
    op("R8 mixed byte sat add", 64'hFF00_FF00_FF00_FF00, 64'h01FF_01FF_01FF_01FF, 0, 0, 1);
    idle("R3 hold after mixed");
    idle("R3 hold again");

    for (int k = 0; k < 400; k++) begin
      op($sformatf("R%0s random %0d", "4/5/6/7/8 (R4 R5 R6 R7 R8)", k),
         lanes_rand(), lanes_rand(), 1'($urandom), 1'($urandom), 1'($urandom));
      if (k % 7 == 0) idle("R3 random hold");
    end

    @(negedge clk); rst = 1; in_valid = 1;
    @(negedge clk); rst = 0; in_valid = 0;
    check("R1 reset mid-run", 64'h0, 8'h0, 1'b0);

    // R2: back-to-back strobes each give a fresh result one cycle later
    @(negedge clk);
    src_a = 64'h10; src_b = 64'h20; fmt_half = 0; op_sub = 0; sat_en = 0; in_valid = 1;
    @(negedge clk);
    check("R2 first of pair", 64'h30, 8'h0, 1'b1);
    src_a = 64'h10; src_b = 64'h20; op_sub = 1; sat_en = 1;
    @(negedge clk);
    in_valid = 0;
    check("R2 second of pair", 64'h0, 8'h01, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule